// File: doc/BRIEF.md
# Self-Timed Byte-Write Controller for a Parallel EEPROM

This block is the control core of a byte-wide non-volatile memory that a host reads and writes like a static RAM. It watches three active-low strobes: chip select, output enable and write enable. The strobes are synchronized to the system clock before use. A write is accepted when chip select and write enable are both low while output enable is high. The block latches the address when the strobe that falls last goes low. It latches the data when the first of chip select or write enable rises.

Once a byte is committed, the block runs a self-timed program cycle of `WR_CYCLES` clocks. The cycle first clears the addressed byte to all ones after `CLR_CYCLES` clocks and then writes the latched byte on the final clock. During this time it pulls the ready line low. Reads made while the cycle runs return a polling pattern instead of array contents. A supply-detect input can veto programming. Writes that arrive during the program cycle are dropped.

The array is a plain register file of `2**ADDR_W` bytes, reset to the erased value 0xFF. Full size is reached with `ADDR_W = 13`.

Top module: `eew_ctrl`

## Requirements
- R1: After reset, `rdy_pull_o` is 0 (line released) and `data_oe_o` is 0.
- R2: The address is taken from `addr_i` two clocks after the later of `ce_ni`/`we_ni` falls. This holds whichever strobe falls last, and later changes of `addr_i` do not move the write.
- R3: The stored byte is the value of `data_i` two clocks after the first of `ce_ni`/`we_ni` rises. Changes of `data_i` after that point have no effect.
- R4: `rdy_pull_o` is 1 for exactly `WR_CYCLES` consecutive clocks per accepted write, starting on the clock at which the data is taken.
- R5: While `rdy_pull_o` is 1, a read of the address being programmed returns bit 7 inverted from the written byte, with bits 6..0 read as 1.
- R6: While `rdy_pull_o` is 1, a read of any other address returns 0xFF, and the array contents of those addresses are unchanged afterwards.
- R7: After the program cycle ends, a read of the written address returns the written byte.
- R8: `data_oe_o` is 1 only when the synchronized chip select and output enable are low and write enable is high. When it is 0, `data_o` is 0x00. With chip select high there is no output, whatever the output enable does.
- R9: If output enable goes low while a write strobe is open, the write is abandoned: no busy period, array unchanged.
- R10: `vcc_low_i` high, at the start of the strobe or at the data capture point, blocks the write: no busy period, array unchanged.
- R11: Write strobes that begin while a program cycle runs are ignored: the busy period is not extended and the target byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select strobe, active low, asynchronous |
| oe_ni | input | 1 | Output enable strobe, active low, asynchronous |
| we_ni | input | 1 | Write enable strobe, active low, asynchronous |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| vcc_low_i | input | 1 | Supply below trip level; blocks programming |
| data_o | output | 8 | Read data, 0x00 when not driven |
| data_oe_o | output | 1 | Enable for the data output buffers |
| rdy_pull_o | output | 1 | Open-drain ready control: 1 pulls the line low (busy), 0 releases it |

## Verification
The bench builds the block with `ADDR_W = 6`, `WR_CYCLES = 24` and `CLR_CYCLES = 8`. A busy window of 24 clocks is short enough that a complete second write strobe fits inside one program cycle, so the ignore rule (R11) can be tested. It also leaves room for two polling reads before completion. The 64-byte array lets the reference model track every location. Neighbouring addresses can then be read back to show that nothing else was touched.

// File: rtl/eew_pkg.sv
package eew_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] ERASED = '1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_BUSY
  } eew_state_e;
endpackage

// File: rtl/eew_sync.sv
module eew_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/eew_timer.sv
module eew_timer #(
  parameter int WR_CYCLES  = 3000,
  parameter int CLR_CYCLES = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clr_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] CLR_AT = CNT_W'(CLR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign clr_o  = run_i && (cnt_q == CLR_AT);
  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  initial begin
    assert (CLR_CYCLES >= 1 && CLR_CYCLES < WR_CYCLES);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R4
endmodule

// File: rtl/eew_ctrl.sv
module eew_ctrl
  import eew_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int WR_CYCLES  = 3000,
  parameter int CLR_CYCLES = 1500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vcc_low_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rdy_pull_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [2:0] strb_s;
  logic ce_s, oe_s, we_s;

  eew_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_ni, oe_ni, we_ni}),
    .q_o   (strb_s)
  );
  assign {ce_s, oe_s, we_s} = strb_s;

  eew_state_e        state_q;
  logic              wact, wact_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_data_q;
  logic              busy, clr_hit, done_hit;
  logic [DATA_W-1:0] mem [DEPTH];

  // write strobe open: both select and write low, output enable high
  assign wact = !ce_s && !we_s && oe_s;
  assign busy = (state_q == ST_BUSY);

  eew_timer #(.WR_CYCLES(WR_CYCLES), .CLR_CYCLES(CLR_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .clr_o (clr_hit),
    .done_o(done_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wact_q     <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else begin
      wact_q <= wact;
      unique case (state_q)
        ST_IDLE: begin
          // fresh rise only: a strobe left open across busy is not restarted
          if (wact && !wact_q && !vcc_low_i) begin
            state_q    <= ST_STROBE;
            lat_addr_q <= addr_i;
          end
        end
        ST_STROBE: begin
          if (!wact) begin
            if (!oe_s || vcc_low_i) state_q <= ST_IDLE;
            else begin
              state_q    <= ST_BUSY;
              lat_data_q <= data_i;
            end
          end
        end
        ST_BUSY: if (done_hit) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (done_hit) begin
      mem[lat_addr_q] <= lat_data_q;
    end else if (clr_hit) begin
      mem[lat_addr_q] <= ERASED;
    end
  end

  logic              rd_en;
  logic [DATA_W-1:0] rd_val;

  assign rd_en = !ce_s && !oe_s && we_s;

  always_comb begin
    if (busy) begin
      if (addr_i == lat_addr_q) rd_val = {~lat_data_q[DATA_W-1], {(DATA_W-1){1'b1}}};
      else                      rd_val = ERASED;
    end else begin
      rd_val = mem[addr_i];
    end
  end

  assign data_oe_o  = rd_en;
  assign data_o     = rd_en ? rd_val : '0;
  assign rdy_pull_o = busy;

  AST_BUSY_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_pull_o) |-> $past(state_q == ST_STROBE)); // R3
  AST_LATCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(lat_addr_q) && $stable(lat_data_q))); // R11
  AST_VCC_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && !wact && vcc_low_i) |=> !rdy_pull_o); // R10
  AST_OE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && !wact && !oe_s) |=> !rdy_pull_o); // R9
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_s |-> (!data_oe_o && data_o == '0)); // R8
  AST_POLL_BIT7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_en && addr_i == lat_addr_q) |-> data_o[DATA_W-1] != lat_data_q[DATA_W-1]); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_hit |=> !rdy_pull_o); // R4
endmodule

// File: tb/eew_ctrl_test.sv
module eew_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WRC = 24;
  localparam int CLRC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic vcc_low = 1'b0;
  logic [7:0] dout;
  logic dout_en, rdy_pull;

  int tests = 0, fails = 0, cycles = 0, busy_cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eew_ctrl #(.ADDR_W(AW), .WR_CYCLES(WRC), .CLR_CYCLES(CLRC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .vcc_low_i(vcc_low),
    .data_o(dout), .data_oe_o(dout_en), .rdy_pull_o(rdy_pull)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: strobe pins seen two clocks late
  int m_mem[64];
  int m_state = 0;  // 0 idle, 1 strobe open, 2 programming
  int m_cnt = 0, m_a = 0, m_d = 0;
  bit m_wq = 0;
  bit m1_ce = 1, m1_oe = 1, m1_we = 1, m_ce = 1, m_oe = 1, m_we = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_state = 0; m_cnt = 0; m_wq = 0;
      {m1_ce, m1_oe, m1_we, m_ce, m_oe, m_we} = 6'b111111;
    end else begin
      bit w;
      w = !m_ce && !m_we && m_oe;
      if (m_state == 0) begin
        if (w && !m_wq && !vcc_low) begin m_state = 1; m_a = int'(addr); end
      end else if (m_state == 1) begin
        if (!w) begin
          if (!m_oe || vcc_low) m_state = 0;
          else begin m_state = 2; m_d = int'(din); m_cnt = 0; end
        end
      end else begin
        if (m_cnt == WRC - 1) begin m_mem[m_a] = m_d; m_state = 0; end
        else m_cnt++;
      end
      m_wq = w;
      {m_ce, m_oe, m_we} = {m1_ce, m1_oe, m1_we};
      {m1_ce, m1_oe, m1_we} = {ce_n, oe_n, we_n};
    end
  end

  // compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      bit rd;
      int exp_d;
      rd = !m_ce && !m_oe && m_we;
      if (!rd) exp_d = 0;
      else if (m_state == 2) exp_d = (int'(addr) == m_a) ? ({~m_d[7], 7'h7F} & 8'hFF) : 8'hFF;
      else exp_d = m_mem[addr];
      check(rdy_pull == (m_state == 2), "R4 ready line", rdy_pull, m_state == 2);
      check(dout_en == rd, "R8 output enable", dout_en, rd);
      check(int'(dout) == exp_d, "R5 R6 R7 read data", dout, exp_d);
    end
  end

  always @(negedge clk) if (rst_n) busy_cycles += int'(rdy_pull);

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_we(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0;
    ticks(2); we_n = 0;
    ticks(4); addr = a + 1'b1;
    ticks(2); we_n = 1;
    ticks(4); din = ~d; ce_n = 1;
    ticks(2);
  endtask

  task automatic wr_ce(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; we_n = 0;
    ticks(2); ce_n = 0;
    ticks(4); addr = a + 1'b1;
    ticks(2); ce_n = 1;
    ticks(4); din = ~d; we_n = 1;
    ticks(2);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    ticks(3);
    check(dout_en == 1'b1, tag, dout_en, 1);
    check(dout == exp, tag, dout, exp);
    oe_n = 1; ce_n = 1;
    ticks(3);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (rdy_pull && n < 200) begin @(negedge clk); n++; end
    ticks(2);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    check(1'b0, "watchdog", cycles, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    ticks(3);
    check(rdy_pull == 0, "R1 ready after reset", rdy_pull, 0);
    check(dout_en == 0, "R1 oe after reset", dout_en, 0);
    rst_n = 1;
    ticks(3);

    // write-enable controlled write, polling, neighbours
    busy_cycles = 0;
    wr_we(6'd5, 8'hA5);
    rd_chk(6'd5, 8'h7F, "R5 poll last address");
    rd_chk(6'd9, 8'hFF, "R6 other address busy");
    wait_ready();
    check(busy_cycles == WRC, "R4 busy length", busy_cycles, WRC);
    rd_chk(6'd5, 8'hA5, "R7 R3 data after completion");
    rd_chk(6'd6, 8'hFF, "R2 moved address untouched");
    rd_chk(6'd9, 8'hFF, "R6 array undisturbed");

    // chip-select controlled write, bit 7 low gives poll bit 7 high
    wr_ce(6'd12, 8'h3C);
    rd_chk(6'd12, 8'hFF, "R5 poll inverted zero bit7");
    wait_ready();
    rd_chk(6'd12, 8'h3C, "R2 chip-select timed write");
    rd_chk(6'd13, 8'hFF, "R2 address after start ignored");

    // output enable low during strobe abandons write
    @(negedge clk); addr = 6'd20; din = 8'h11; ce_n = 0;
    ticks(2); we_n = 0;
    ticks(4); oe_n = 0;
    ticks(3); we_n = 1; ce_n = 1;
    ticks(3); oe_n = 1;
    ticks(3);
    check(rdy_pull == 0, "R9 no busy after inhibit", rdy_pull, 0);
    rd_chk(6'd20, 8'hFF, "R9 array unchanged");

    // supply low at start
    vcc_low = 1;
    wr_we(6'd21, 8'h22);
    check(rdy_pull == 0, "R10 blocked at start", rdy_pull, 0);
    vcc_low = 0;
    // supply drops before data capture
    @(negedge clk); addr = 6'd22; din = 8'h33; ce_n = 0;
    ticks(2); we_n = 0;
    ticks(4); vcc_low = 1;
    ticks(1); we_n = 1;
    ticks(4); ce_n = 1; vcc_low = 0;
    ticks(2);
    check(rdy_pull == 0, "R10 blocked at capture", rdy_pull, 0);
    rd_chk(6'd21, 8'hFF, "R10 first byte unchanged");
    rd_chk(6'd22, 8'hFF, "R10 second byte unchanged");

    // second write inside busy window is dropped
    busy_cycles = 0;
    wr_we(6'd30, 8'h81);
    wr_we(6'd40, 8'h18);
    wait_ready();
    check(busy_cycles == WRC, "R11 busy not extended", busy_cycles, WRC);
    rd_chk(6'd40, 8'hFF, "R11 ignored target unchanged");
    rd_chk(6'd30, 8'h81, "R7 first write kept");

    // standby and write-inhibit read combinations
    @(negedge clk); addr = 6'd5; oe_n = 0; ce_n = 1;
    ticks(3);
    check(dout_en == 0, "R8 standby with oe low", dout_en, 0);
    check(dout == 0, "R8 data zero in standby", dout, 0);
    we_n = 0; ce_n = 0;
    ticks(3);
    check(dout_en == 0, "R8 no read with we low", dout_en, 0);
    check(rdy_pull == 0, "R9 no write with oe low", rdy_pull, 0);
    ce_n = 1; we_n = 1; oe_n = 1;
    ticks(4);
    rd_chk(6'd5, 8'hA5, "R8 read restored");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule